// File: doc/BRIEF.md
# Three-Way Fixed-Priority Arbiter with Name Display

This block shares one resource among three requesters, A, B and C. A ranks above B and B ranks above C. It is a clocked state machine with one idle state and one state for each requester. A grant is issued only from the idle state, and the winner is the highest-ranked request that is high at that moment. A granted requester keeps its grant for as long as its own request stays high, even if a higher-ranked request arrives. When the holder drops its request, the machine spends one cycle idle with every grant low. It then arbitrates again. So two grants are always separated by at least one idle cycle.

Beside the grant lines, the block spells out the winner's name on eight seven-segment digits. The names read "ProcessA", "Processb" or "ProcessC". Lowercase shapes are used where a letter has no clean uppercase form on seven segments. When no grant is active, all eight digits are dark. The grants are registered, and the digit patterns are decoded from them without further delay, so the name changes in the same cycle as the grant.

Top module: `prio_arb_disp`

## Requirements
- R1: When `rst_n` is sampled low at a rising clock edge, all three grants are low after that edge and all digits are blank. This holds even if a grant was active before.
- R2: From idle, the highest-ranked active request wins (A over B over C). Requests A=B=C=1 give {gnt_a,gnt_b,gnt_c}=100, and B=C=1 gives 010.
- R3: From idle, with only C requesting, the grant vector becomes 001.
- R4: At most one of the three grants is high in any cycle.
- R5: While the granted requester keeps its request high, its grant stays high. Requests from higher-ranked requesters do not take the grant away.
- R6: In the cycle after the holder's request is sampled low, all grants are low. If requests are still pending, the next grant follows one cycle later.
- R7: A grant never passes directly to a different grant. The cycle after any grant is high shows either the same grant or no grant.
- R8: When idle with no request, all grants stay low and every digit shows the blank pattern 7'h7F.
- R9: Digit i sits on `seg_n[7*i+6:7*i]`. Its bit order is g,f,e,d,c,b,a from bit 6 down to bit 0, and a 0 turns a segment on. While a grant is high, digits 0..6 show P=0C, r=2F, o=23, c=27, e=04, s=12, s=12 (hex). Digit 7 shows A=08 for A, b=03 for B and C=46 for C.
- R10: A request sampled at a rising edge while idle produces its grant right after that same edge, a latency of one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_a | input | 1 | Request from A (highest rank) |
| req_b | input | 1 | Request from B |
| req_c | input | 1 | Request from C (lowest rank) |
| gnt_a | output | 1 | Grant to A |
| gnt_b | output | 1 | Grant to B |
| gnt_c | output | 1 | Grant to C |
| seg_n | output | 56 | Eight active-low 7-segment patterns, digit i at bits 7*i+6..7*i |

## Verification
Some properties are checked on every cycle: grant exclusivity, the ban on a direct change from one grant to another, the holding of a grant under a high request, the forced idle after a release, priority on entry from idle, and dark digits without a grant. Other behaviours only show in the bench's scenarios: the exact grant vector for each of the seven request patterns, the glyph values spelling each name, the order in which pending requesters are served after a release, and a reset that lands in the middle of a grant.

// File: rtl/prio_arb_pkg.sv
// Shared types and glyph encodings for the three-way arbiter.
// Assumes active-low segments, bit order g..a from bit 6 to bit 0.
package prio_arb_pkg;

    localparam int NUM_REQ  = 3;
    localparam int SEG_BITS = 7;
    localparam int NUM_DIG  = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_A    = 2'd1,
        ST_B    = 2'd2,
        ST_C    = 2'd3
    } arb_state_e;

    localparam logic [SEG_BITS-1:0] GL_BLANK = 7'h7F;
    localparam logic [SEG_BITS-1:0] GL_P     = 7'h0C;
    localparam logic [SEG_BITS-1:0] GL_R     = 7'h2F;
    localparam logic [SEG_BITS-1:0] GL_O     = 7'h23;
    localparam logic [SEG_BITS-1:0] GL_CL    = 7'h27;
    localparam logic [SEG_BITS-1:0] GL_E     = 7'h04;
    localparam logic [SEG_BITS-1:0] GL_S     = 7'h12;
    localparam logic [SEG_BITS-1:0] GL_A     = 7'h08;
    localparam logic [SEG_BITS-1:0] GL_B     = 7'h03;
    localparam logic [SEG_BITS-1:0] GL_CU    = 7'h46;

    // Glyph for one digit position given the one-hot grant (bit 2 = A).
    function automatic logic [SEG_BITS-1:0] glyph_for(input int pos,
                                                      input logic [NUM_REQ-1:0] gnt);
        logic [SEG_BITS-1:0] g;
        if (gnt == '0) begin
            g = GL_BLANK;
        end else begin
            case (pos)
                0:       g = GL_P;
                1:       g = GL_R;
                2:       g = GL_O;
                3:       g = GL_CL;
                4:       g = GL_E;
                5:       g = GL_S;
                6:       g = GL_S;
                7: begin
                    if (gnt[2])      g = GL_A;
                    else if (gnt[1]) g = GL_B;
                    else             g = GL_CU;
                end
                default: g = GL_BLANK;
            endcase
        end
        return g;
    endfunction

endpackage

// File: rtl/arb_fsm.sv
// Fixed-priority arbitration state machine with a mandatory idle step.
// Grants are registered and decoded from the next state; bit 2 = A, bit 0 = C.
// Assumes synchronous active-low reset and requests stable around the clock edge.
module arb_fsm
    import prio_arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] req,
    output logic [NUM_REQ-1:0] gnt
);

    arb_state_e state_q;
    arb_state_e state_d;

    // Next state: grants are issued only from idle; a holder keeps or releases.
    always_comb begin
        state_d = ST_IDLE;
        case (state_q)
            ST_IDLE: begin
                if (req[2])      state_d = ST_A;
                else if (req[1]) state_d = ST_B;
                else if (req[0]) state_d = ST_C;
                else             state_d = ST_IDLE;
            end
            ST_A:    state_d = req[2] ? ST_A : ST_IDLE;
            ST_B:    state_d = req[1] ? ST_B : ST_IDLE;
            ST_C:    state_d = req[0] ? ST_C : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State and registered one-hot grant update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            gnt     <= '0;
        end else begin
            state_q <= state_d;
            case (state_d)
                ST_A:    gnt <= 3'b100;
                ST_B:    gnt <= 3'b010;
                ST_C:    gnt <= 3'b001;
                default: gnt <= 3'b000;
            endcase
        end
    end

    // R4
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R7
    no_direct_handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != '0) |=> (gnt == '0) || (gnt == $past(gnt)));

    // R5
    hold_while_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt & req) != '0) |=> (gnt == $past(gnt)));

    // R6
    idle_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt != '0) && ((gnt & req) == '0)) |=> (gnt == '0));

    // R2
    a_wins_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt == '0) && req[2]) |=> (gnt == 3'b100));

    // R3
    c_alone_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt == '0) && (req == 3'b001)) |=> (gnt == 3'b001));

endmodule

// File: rtl/name_seg_decode.sv
// Turns the one-hot grant into eight active-low seven-segment glyphs that
// spell the holder's name; all digits dark when no grant is active.
// Assumes digit i on bits [7*i+6:7*i], digit 0 holding the first letter.
module name_seg_decode
    import prio_arb_pkg::*;
(
    input  logic [NUM_REQ-1:0]          gnt,
    output logic [NUM_DIG*SEG_BITS-1:0] seg_n
);

    // One glyph lookup per digit position.
    for (genvar d = 0; d < NUM_DIG; d++) begin : g_dig
        assign seg_n[d*SEG_BITS +: SEG_BITS] = glyph_for(d, gnt);
    end

endmodule

// File: rtl/prio_arb_disp.sv
// Top: three-way fixed-priority arbiter (A > B > C) with forced idle between
// grants, plus a name display on eight seven-segment digits.
// Assumes synchronous active-low reset; outputs change only after a clock edge.
module prio_arb_disp
    import prio_arb_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_a,
    input  logic                        req_b,
    input  logic                        req_c,
    output logic                        gnt_a,
    output logic                        gnt_b,
    output logic                        gnt_c,
    output logic [NUM_DIG*SEG_BITS-1:0] seg_n
);

    logic [NUM_REQ-1:0] req_v;
    logic [NUM_REQ-1:0] gnt_v;

    // Pack requests with A in the top bit.
    assign req_v = {req_a, req_b, req_c};

    arb_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req_v),
        .gnt   (gnt_v)
    );

    name_seg_decode u_disp (
        .gnt   (gnt_v),
        .seg_n (seg_n)
    );

    // Split the grant vector onto the output pins.
    assign gnt_a = gnt_v[2];
    assign gnt_b = gnt_v[1];
    assign gnt_c = gnt_v[0];

    // R8
    dark_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gnt_a && !gnt_b && !gnt_c) |-> (seg_n == '1));

endmodule

// File: tb/sim_prio_arb_disp.sv
module sim_prio_arb_disp;

    localparam time CLK_PERIOD = 10ns;

    typedef struct {
        logic [2:0] gnt;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_a = 1'b0, req_b = 1'b0, req_c = 1'b0;
    logic        gnt_a, gnt_b, gnt_c;
    logic [55:0] seg_n;

    exp_t exp_q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_arb_disp u0 (
        .clk(clk), .rst_n(rst_n),
        .req_a(req_a), .req_b(req_b), .req_c(req_c),
        .gnt_a(gnt_a), .gnt_b(gnt_b), .gnt_c(gnt_c),
        .seg_n(seg_n)
    );

    // Expected display image per R8/R9.
    function automatic logic [55:0] exp_seg(input logic [2:0] g);
        logic [6:0]  name [0:6];
        logic [55:0] s;
        name[0] = 7'h0C; name[1] = 7'h2F; name[2] = 7'h23; name[3] = 7'h27;
        name[4] = 7'h04; name[5] = 7'h12; name[6] = 7'h12;
        if (g == 3'b000) return {56{1'b1}};
        for (int i = 0; i < 7; i++) s[7*i +: 7] = name[i];
        s[49 +: 7] = (g == 3'b100) ? 7'h08 : (g == 3'b010) ? 7'h03 : 7'h46;
        return s;
    endfunction

    // Priority winner per R2/R3.
    function automatic logic [2:0] winner(input logic [2:0] r);
        if (r[2]) return 3'b100;
        if (r[1]) return 3'b010;
        if (r[0]) return 3'b001;
        return 3'b000;
    endfunction

    // Driver: set inputs before the edge and queue the expected result.
    task automatic drive(input logic rn, input logic [2:0] r,
                         input logic [2:0] g, input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = rn;
        {req_a, req_b, req_c} = r;
        e.gnt = g;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: after each edge, pop and compare against the ports.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                logic [2:0] act;
                e = exp_q.pop_front();
                act = {gnt_a, gnt_b, gnt_c};
                n_vec++;
                if (act !== e.gnt) begin
                    n_bad++;
                    $display("FAIL %s grant: actual %b expected %b", e.tag, act, e.gnt);
                end
                if (seg_n !== exp_seg(e.gnt)) begin
                    n_bad++;
                    $display("FAIL %s seg_n: actual %h expected %h", e.tag, seg_n, exp_seg(e.gnt));
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        drive(1'b0, 3'b111, 3'b000, "R1 reset");
        drive(1'b0, 3'b111, 3'b000, "R1 reset");
        drive(1'b1, 3'b000, 3'b000, "R8 idle");
        drive(1'b1, 3'b000, 3'b000, "R8 idle");
        drive(1'b1, 3'b111, 3'b100, "R2 all high, R9 name A, R10");
        drive(1'b1, 3'b111, 3'b100, "R5 hold A");
        drive(1'b1, 3'b011, 3'b000, "R6 A released");
        drive(1'b1, 3'b011, 3'b010, "R2 B over C");
        drive(1'b1, 3'b111, 3'b010, "R5 no preempt by A");
        drive(1'b1, 3'b101, 3'b000, "R7 idle before A");
        drive(1'b1, 3'b101, 3'b100, "R6 re-arbitrate to A");
        drive(1'b1, 3'b001, 3'b000, "R6 A released");
        drive(1'b1, 3'b001, 3'b001, "R3 only C");
        drive(1'b1, 3'b001, 3'b001, "R5 hold C");
        drive(1'b1, 3'b000, 3'b000, "R8 back to idle");
        drive(1'b1, 3'b000, 3'b000, "R8 stay idle");
        drive(1'b1, 3'b010, 3'b010, "R10 B one-clock latency");
        drive(1'b1, 3'b000, 3'b000, "R6 B released");
        // R4 R9: every request pattern from idle.
        for (int v = 1; v < 8; v++) begin
            drive(1'b1, v[2:0], winner(v[2:0]), "R4 pattern sweep");
            drive(1'b1, 3'b000, 3'b000, "R6 sweep release");
        end
        drive(1'b1, 3'b001, 3'b001, "R3 C before reset");
        drive(1'b0, 3'b001, 3'b000, "R1 reset mid-grant");
        drive(1'b1, 3'b000, 3'b000, "R8 after reset");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule